// File: doc/BRIEF.md
# Thirteen-Level Multicarrier Comparator Modulator

This block turns a stream of signed reference samples into a step level for a thirteen-level power stage. Inside, twelve triangular carriers are built from small up/down counters. Each carrier sits in its own horizontal band of equal height, and the twelve bands are stacked to cover the full reference range. The latest reference sample is compared with every carrier on every clock. The result is a thermometer-coded vector of comparator bits and a signed level from -6 to +6.

The carriers can be arranged in four ways, chosen at run time:
- all in step;
- the upper six inverted against the lower six;
- every band inverted against its neighbour;
- a frequency ladder in which each carrier runs twice as fast as the one above it.

A common prescaler sets the carrier rate. A new arrangement takes effect only at the end of a full carrier frame, and at that point every carrier counter is reloaded, so the output never shows a partial period. Upstream logic supplies the sine samples. Gate mapping and dead time are handled downstream.

Top module: `mcpwm_level_gen`

## Requirements
- R1: While reset is held, `lvl_o` is 0 and `cmp_o` has its lower six bits set and its upper six bits clear.
- R2: With band height B = 2^BAND_W and carrier k (k = 0 lowest) taking values (k-6)*B + t, where t is between 0 and B-1, bit k of `cmp_o` is 1 exactly when the held reference is strictly greater than carrier k. `lvl_o` equals the number of upper carriers (k of 6 or more) that the reference exceeds, minus the number of lower carriers (k of 5 or less) that the reference does not exceed. `cmp_o` is therefore always a thermometer code.
- R3: A reference of 0 holds `lvl_o` at 0 in every mode and at every carrier phase.
- R4: A reference of 6*B or more gives +6, and a reference of -6*B or less gives -6, at every carrier phase.
- R5: The carrier tick fires once every `per_i`+1 clocks. On each tick a carrier advances one step. Its value t runs 0,1,…,B-1,B-1,…,1,0, so it holds each extreme for two steps and has a period of 2*B steps.
- R6: Mode code 0 (all in step): every carrier starts at t=0 rising, and all twelve carriers stay equal.
- R7: Mode code 1 (split): carriers 6 to 11 start at t=0 rising, and carriers 0 to 5 start at t=B-1 falling.
- R8: Mode code 2 (alternating): even-indexed carriers start at t=0 rising, and odd-indexed carriers start at t=B-1 falling.
- R9: Mode code 3 (ladder): all carriers start at t=0 rising, and carrier k advances only on every 2^k-th tick. Each carrier therefore runs at twice the frequency of the carrier above it.
- R10: The active mode changes only at a frame end: after 2*B ticks in codes 0 to 2, or after 2*B*2^11 ticks in code 3. At that point the mode is taken from `mode_i` and every carrier is reloaded to its start state. Reset also takes the mode from `mode_i`.
- R11: The reference is captured only in a cycle with `ref_vld_i` high. Otherwise `ref_i` has no effect on the output.
- R12: The outputs are registered. The values present after a clock edge reflect the reference and carrier state held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Carrier arrangement code (0 to 3) |
| ref_i | input | REF_W | Signed reference sample |
| ref_vld_i | input | 1 | Reference capture strobe |
| per_i | input | PER_W | Prescaler setting; tick every per_i+1 clocks |
| lvl_o | output | LVL_W | Signed output level, -6 to +6 |
| cmp_o | output | 12 | Comparator results, bit k for carrier k |

## Verification
The assertions assume the following about the inputs:
- `mode_i` is stable during the last reset cycle, so that the first mode seen after reset is the loaded one.
- The reference uses the same scale as the carriers, with a full scale of ±6*B inside the REF_W range.

The stimulus holds `mode_i` fixed while reset is low. It sweeps references only within ±(6*B+6), which fits an 8-bit word for the small band height used. Mode and prescaler changes are made between clock edges, so every change lands at an arbitrary frame phase, and the R10 rule is what decides when each change takes effect.

// File: rtl/mcpwm_pkg.sv
// Shared types for the multicarrier level generator.
// Assumes: carriers are indexed from the lowest band (0) upward.
package mcpwm_pkg;

    typedef enum logic [1:0] {
        DISP_INPHASE = 2'd0,
        DISP_SPLIT   = 2'd1,
        DISP_ALT     = 2'd2,
        DISP_LADDER  = 2'd3
    } disp_mode_e;

    // Whether carrier idx begins its frame at the top of its band, falling.
    function automatic logic start_high(disp_mode_e m, int idx, int half);
        case (m)
            DISP_SPLIT: return (idx < half);
            DISP_ALT:   return ((idx % 2) == 1);
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/mcpwm_timebase.sv
// Carrier time base: prescaler tick, frame counter and the active mode.
// The active mode is replaced from mode_i only at a frame end (or in reset).
// Assumes: per_i may change at any time; the tick adapts on the next compare.
module mcpwm_timebase
    import mcpwm_pkg::*;
#(
    parameter int NCAR   = 12,
    parameter int BAND_W = 4,
    parameter int PER_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  disp_mode_e                mode_i,
    input  logic [PER_W-1:0]          per_i,
    output logic                      tick_o,
    output logic                      bnd_o,
    output logic [BAND_W+NCAR-1:0]    frame_o,
    output disp_mode_e                mode_o
);
    localparam int FRAME_W    = BAND_W + NCAR;
    localparam int SHORT_LAST = 2 * (1 << BAND_W) - 1;

    logic [PER_W-1:0]   pc;
    logic [FRAME_W-1:0] last;

    assign tick_o = (pc >= per_i);
    assign last   = (mode_o == DISP_LADDER) ? '1 : FRAME_W'(SHORT_LAST);
    assign bnd_o  = tick_o && (frame_o == last);

    // Prescaler: count clocks between carrier ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)      pc <= '0;
        else if (tick_o) pc <= '0;
        else             pc <= pc + 1'b1;
    end

    // Frame position and mode latch at frame boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_o <= '0;
            mode_o  <= mode_i;
        end else if (bnd_o) begin
            frame_o <= '0;
            mode_o  <= mode_i;
        end else if (tick_o) begin
            frame_o <= frame_o + 1'b1;
        end
    end

endmodule

// File: rtl/mcpwm_carrier.sv
// One triangular carrier inside its band: an up/down counter over 0..2^BAND_W-1
// that holds each extreme for one extra step (period 2*2^BAND_W steps).
// Assumes: load_i has priority over step_i.
module mcpwm_carrier #(
    parameter int BAND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              start_hi_i,
    input  logic              step_i,
    output logic [BAND_W-1:0] val_o
);
    localparam logic [BAND_W-1:0] TOP = '1;

    logic down;

    // Counter: reload to the start extreme, else walk the triangle.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) begin
            val_o <= start_hi_i ? TOP : '0;
            down  <= start_hi_i;
        end else if (step_i) begin
            if (down) begin
                if (val_o == '0) down  <= 1'b0;
                else             val_o <= val_o - 1'b1;
            end else begin
                if (val_o == TOP) down  <= 1'b1;
                else              val_o <= val_o + 1'b1;
            end
        end
    end

endmodule

// File: rtl/mcpwm_slicer.sv
// Reference capture, band comparators and level count.
// Carrier k lives at (k-HALF)*BAND + car_i[k]; bit k is set when ref > carrier.
// Assumes: REF_W is wide enough to hold +/- HALF*BAND.
module mcpwm_slicer #(
    parameter int NCAR   = 12,
    parameter int BAND_W = 4,
    parameter int REF_W  = 12,
    parameter int LVL_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [REF_W-1:0] ref_i,
    input  logic                    ref_vld_i,
    input  logic [BAND_W-1:0]       car_i [NCAR],
    output logic signed [REF_W-1:0] ref_q_o,
    output logic signed [LVL_W-1:0] lvl_o,
    output logic [NCAR-1:0]         cmp_o
);
    localparam int HALF  = NCAR / 2;
    localparam int BAND  = 1 << BAND_W;
    localparam int CW    = REF_W + 2;
    localparam int CNT_W = $clog2(NCAR + 1);
    localparam logic [NCAR-1:0] LOW_MASK = {{(NCAR-HALF){1'b0}}, {HALF{1'b1}}};

    logic [NCAR-1:0]      cmp_now;
    logic signed [CW-1:0] ref_ext;
    logic [CNT_W-1:0]     cnt_now;

    assign ref_ext = CW'(ref_q_o);

    // Reference register: take a new sample only on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         ref_q_o <= '0;
        else if (ref_vld_i) ref_q_o <= ref_i;
    end

    for (genvar k = 0; k < NCAR; k++) begin : g_cmp
        localparam int BASE = (k - HALF) * BAND;
        logic signed [CW-1:0] car_abs;
        assign car_abs    = CW'(BASE) + CW'(car_i[k]);
        assign cmp_now[k] = (ref_ext > car_abs);
    end

    // Count of set comparator bits.
    always_comb begin
        cnt_now = '0;
        for (int i = 0; i < NCAR; i++) cnt_now = cnt_now + CNT_W'(cmp_now[i]);
    end

    // Output register: comparator vector and signed level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_o <= LOW_MASK;
            lvl_o <= '0;
        end else begin
            cmp_o <= cmp_now;
            lvl_o <= LVL_W'(cnt_now) - LVL_W'(HALF);
        end
    end

endmodule

// File: rtl/mcpwm_level_gen.sv
// Multicarrier level generator for an odd LEVELS-level stage.
// Builds LEVELS-1 stacked carriers whose phase/frequency pattern follows the
// active mode, compares them against the sampled reference, outputs the level.
// Assumes: mode_i codes per mcpwm_pkg::disp_mode_e; reference on carrier scale.
module mcpwm_level_gen
    import mcpwm_pkg::*;
#(
    parameter int LEVELS = 13,
    parameter int BAND_W = 4,
    parameter int REF_W  = 12,
    parameter int PER_W  = 16,
    parameter int LVL_W  = $clog2((LEVELS - 1) / 2 + 1) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              mode_i,
    input  logic signed [REF_W-1:0] ref_i,
    input  logic                    ref_vld_i,
    input  logic [PER_W-1:0]        per_i,
    output logic signed [LVL_W-1:0] lvl_o,
    output logic [LEVELS-2:0]       cmp_o
);
    localparam int NCAR    = LEVELS - 1;
    localparam int HALF    = NCAR / 2;
    localparam int FRAME_W = BAND_W + NCAR;

    disp_mode_e               mode_in;
    disp_mode_e               mode_r;
    logic [1:0]               mode_r_bits;
    logic                     tick;
    logic                     bnd;
    logic [FRAME_W-1:0]       frame;
    logic [BAND_W-1:0]        car_v [NCAR];
    logic [NCAR*BAND_W-1:0]   car_flat;
    logic signed [REF_W-1:0]  ref_q;

    assign mode_in     = disp_mode_e'(mode_i);
    assign mode_r_bits = mode_r;

    mcpwm_timebase #(.NCAR(NCAR), .BAND_W(BAND_W), .PER_W(PER_W)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode_in),
        .per_i   (per_i),
        .tick_o  (tick),
        .bnd_o   (bnd),
        .frame_o (frame),
        .mode_o  (mode_r)
    );

    for (genvar k = 0; k < NCAR; k++) begin : g_car
        localparam logic [FRAME_W-1:0] MASK = FRAME_W'((64'd1 << k) - 64'd1);
        logic step_k;
        logic hi_k;
        assign step_k = tick && ((mode_r != DISP_LADDER) || ((frame & MASK) == MASK));
        assign hi_k   = start_high(mode_in, k, HALF);

        mcpwm_carrier #(.BAND_W(BAND_W)) u_car (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (bnd),
            .start_hi_i (hi_k),
            .step_i     (step_k),
            .val_o      (car_v[k])
        );
        assign car_flat[k*BAND_W +: BAND_W] = car_v[k];
    end

    mcpwm_slicer #(.NCAR(NCAR), .BAND_W(BAND_W), .REF_W(REF_W), .LVL_W(LVL_W)) u_slc (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_i     (ref_i),
        .ref_vld_i (ref_vld_i),
        .car_i     (car_v),
        .ref_q_o   (ref_q),
        .lvl_o     (lvl_o),
        .cmp_o     (cmp_o)
    );

endmodule

// File: rtl/mcpwm_level_gen_chk.sv
// Property checker for mcpwm_level_gen, attached by bind below.
// Assumes: mode_i is steady across the last reset cycle.
module mcpwm_level_gen_chk #(
    parameter int NCAR   = 12,
    parameter int BAND_W = 4,
    parameter int REF_W  = 12,
    parameter int LVL_W  = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic signed [LVL_W-1:0] lvl_o,
    input logic [NCAR-1:0]         cmp_o,
    input logic [1:0]              mode_r,
    input logic                    bnd,
    input logic signed [REF_W-1:0] ref_q,
    input logic                    ref_vld,
    input logic [NCAR*BAND_W-1:0]  car_flat
);
    localparam int HALF = NCAR / 2;
    localparam int FULL = HALF * (1 << BAND_W);

    assert_thermo_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_o & (cmp_o + 1'b1)) == '0);

    assert_level_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(lvl_o) == ($countones(cmp_o) - HALF));

    assert_zero_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ref_q) == '0) |-> (lvl_o == '0));

    assert_full_pos_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (int'($past(ref_q)) >= FULL) |-> (int'(lvl_o) == HALF));

    assert_full_neg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (int'($past(ref_q)) <= -FULL) |-> (int'(lvl_o) == -HALF));

    assert_inphase_equal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_r == 2'd0) |-> (car_flat == {NCAR{car_flat[BAND_W-1:0]}}));

    assert_mode_at_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_r) |-> $past(bnd));

    assert_ref_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ref_vld) |-> $stable(ref_q));

endmodule

bind mcpwm_level_gen mcpwm_level_gen_chk #(
    .NCAR(NCAR), .BAND_W(BAND_W), .REF_W(REF_W), .LVL_W(LVL_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl_o    (lvl_o),
    .cmp_o    (cmp_o),
    .mode_r   (mode_r_bits),
    .bnd      (bnd),
    .ref_q    (ref_q),
    .ref_vld  (ref_vld_i),
    .car_flat (car_flat)
);

// File: tb/mcpwm_level_gen_tb_top.sv
// Self-checking bench: small band (B=4), cycle-by-cycle comparison against an
// arithmetic carrier model derived from the requirements.
module mcpwm_level_gen_tb_top;
    localparam int LEVELS = 13;
    localparam int BAND_W = 2;
    localparam int REF_W  = 8;
    localparam int PER_W  = 4;
    localparam int NC     = LEVELS - 1;
    localparam int H      = NC / 2;
    localparam int B      = 1 << BAND_W;
    localparam int VF_LEN = 2 * B * (1 << (NC - 1));

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [1:0]              mode = 2'd0;
    logic signed [REF_W-1:0] ref_in = '0;
    logic                    vld = 1'b0;
    logic [PER_W-1:0]        per = '0;
    logic signed [3:0]       lvl_o;
    logic [NC-1:0]           cmp_o;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    mcpwm_level_gen #(.LEVELS(LEVELS), .BAND_W(BAND_W), .REF_W(REF_W), .PER_W(PER_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .ref_i(ref_in), .ref_vld_i(vld),
        .per_i(per), .lvl_o(lvl_o), .cmp_o(cmp_o)
    );

    // Expected comparator vector from the band/phase rules (R2, R5-R9).
    function automatic logic [NC-1:0] want(int r, int md, int f);
        logic [NC-1:0] w;
        for (int k = 0; k < NC; k++) begin
            int s; int p; int tv; int car; bit hi;
            s  = (md == 3) ? (f >> k) : f;
            p  = s % (2 * B);
            hi = (md == 1) ? (k < H) : (md == 2) ? ((k % 2) == 1) : 1'b0;
            if (hi) p = (p + B) % (2 * B);
            tv  = (p < B) ? p : (2 * B - 1 - p);
            car = (k - H) * B + tv;
            w[k] = (r > car);
        end
        return w;
    endfunction

    int            m_f, m_pc, m_mode, m_ref, e_lvl;
    logic [NC-1:0] e_cmp;

    // Reference model, advanced on each rising edge (R10 boundary, R11, R12).
    always @(posedge clk) begin : mdl
        logic [NC-1:0] w;
        int lastf;
        if (!rst_n) begin
            m_mode <= mode; m_f <= 0; m_pc <= 0; m_ref <= 0;
            e_cmp  <= {{(NC-H){1'b0}}, {H{1'b1}}};
            e_lvl  <= 0;
        end else begin
            w = want(m_ref, m_mode, m_f);
            e_cmp <= w;
            e_lvl <= $countones(w) - H;
            lastf = (m_mode == 3) ? VF_LEN - 1 : 2 * B - 1;
            if (m_pc >= int'(per)) begin
                m_pc <= 0;
                if (m_f == lastf) begin m_f <= 0; m_mode <= mode; end
                else m_f <= m_f + 1;
            end else m_pc <= m_pc + 1;
            if (vld) m_ref <= ref_in;
        end
    end

    task automatic chk(string req);
        int got;
        got = lvl_o;
        total++;
        if (got != e_lvl || cmp_o !== e_cmp) begin
            bad++;
            $display("FAIL %s: lvl=%0d exp=%0d cmp=%h exp=%h", req, got, e_lvl, cmp_o, e_cmp);
        end
    endtask

    task automatic chk_lvl(string req, int exp_l);
        int got;
        got = lvl_o;
        total++;
        if (got != exp_l) begin
            bad++;
            $display("FAIL %s: lvl=%0d exp=%0d", req, got, exp_l);
        end
    endtask

    // One cycle: check the current outputs, then drive the next inputs.
    task automatic step(string req, int r, bit v);
        @(negedge clk);
        chk(req);
        ref_in = REF_W'(r);
        vld    = v;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run hung, exp=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk_lvl("R1", 0);
        total++;
        if (cmp_o !== 12'h03F) begin
            bad++; $display("FAIL R1: cmp=%h exp=%h", cmp_o, 12'h03F);
        end
        rst_n = 1'b1;

        // R2 R6 R12: in-step carriers, ramp sweep
        for (int i = 0; i < 240; i++) step("R2 R6 R12", (i % 55) - 27, 1'b1);

        // R5: slower tick
        per = 4'd2;
        for (int i = 0; i < 160; i++) step("R5", ((i * 3) % 55) - 27, 1'b1);
        per = 4'd0;

        // R3: zero reference, explicit and model
        for (int i = 0; i < 40; i++) step("R3", 0, 1'b1);
        @(negedge clk); chk_lvl("R3", 0);

        // R7 R10: switch to split mode mid-frame
        mode = 2'd1;
        for (int i = 0; i < 120; i++) step("R7 R10", ((i * 5) % 55) - 27, 1'b1);
        for (int i = 0; i < 30; i++) step("R3", 0, 1'b1);

        // R8: alternating
        mode = 2'd2;
        for (int i = 0; i < 120; i++) step("R8 R10", ((i * 7) % 55) - 27, 1'b1);

        // R4: full scale both ways
        for (int i = 0; i < 20; i++) step("R4", 24, 1'b1);
        @(negedge clk); chk_lvl("R4", 6);
        for (int i = 0; i < 20; i++) step("R4", -24, 1'b1);
        @(negedge clk); chk_lvl("R4", -6);
        for (int i = 0; i < 10; i++) step("R4", 30, 1'b1);
        for (int i = 0; i < 10; i++) step("R4", -30, 1'b1);

        // R11: strobe low, input changes ignored
        for (int i = 0; i < 4; i++) step("R11", 24, 1'b1);
        for (int i = 0; i < 30; i++) step("R11", -20 + i, 1'b0);
        @(negedge clk); chk_lvl("R11", 6);

        // R9: ladder over a whole slow frame
        mode = 2'd3;
        for (int i = 0; i < VF_LEN + 60; i++) step("R9", ((i / 7) % 55) - 27, 1'b1);

        // R10: leave ladder only at its frame end
        mode = 2'd0;
        for (int i = 0; i < VF_LEN; i++) step("R10", ((i / 3) % 55) - 27, 1'b1);
        for (int i = 0; i < 40; i++) step("R6 R10", ((i * 11) % 55) - 27, 1'b1);

        finish_run();
    end

endmodule